// File: doc/BRIEF.md
# Spindle Motor Drive Modulator

This block turns a drive request into two one-bit motor drive lines, one for each direction, and two switch controls for the power stage. A two-bit mode field picks one of four behaviours. Shutdown drives nothing and keeps both switches open. Start pushes the motor forward at a programmed fixed level, and stop brakes it in reverse at that same level. In both of these the loop demand is ignored. Closed loop follows a signed demand: the sign picks the active line and the magnitude sets the drive strength.

A format bit picks how the strength is expressed. Pulse-width output comes from a free-running 8-bit period counter. Pulse-density output comes from the carry of a first-order sigma-delta accumulator. In both formats, any 256 consecutive cycles carry exactly as many active cycles as the magnitude.

In closed loop, a demand magnitude above the modulator's full scale is an overflow. The drive saturates at full scale and a level interrupt is raised. When the cut-off bit is set, the overflow also opens both drive switches. The interrupt falls and the switches reclose as soon as the demand returns to the modulator's range.

Top module: `motor_drive_mod`

## Requirements
- R1: While reset is held, both drive lines, both switch controls and the interrupt are low.
- R2: In shutdown (mode 0), both drive lines, both switch controls and the interrupt stay low whatever the demand is.
- R3: In start (mode 1), the forward line is active for exactly fixed_level cycles out of every 256, the reverse line stays low, and the demand has no effect.
- R4: In stop (mode 2), the reverse line is active for exactly fixed_level cycles out of every 256, and the forward line stays low.
- R5: In closed loop (mode 3), a non-negative demand drives only the forward line and a negative demand drives only the reverse line. The active line's count per 256 cycles equals the demand magnitude. The two lines are never high together.
- R6: With the format bit at 0 (pulse width), the active line is high in one contiguous run per 256-cycle period, so there is one rising edge per period for a level between 1 and 255.
- R7: With the format bit at 1 (pulse density), the ones are spread by a sigma-delta accumulator. A level of 128 gives alternating ones and zeros, which is 128 rising edges per 256 cycles.
- R8: In closed loop, a demand magnitude above 255 raises the interrupt one clock later. The interrupt falls one clock after the magnitude returns to 255 or less. It never rises outside closed loop.
- R9: During overflow, the active line is driven at full scale, 255 cycles out of 256.
- R10: With the cut-off bit at 1, overflow opens both switch controls in the same cycle that the interrupt rises, and they reclose when it falls. With the bit at 0, the switches stay closed through an overflow.
- R11: In start, stop and closed loop without a cut-off, both switch controls are high one clock after the mode is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_mode | input | 2 | 0 shutdown, 1 start, 2 stop, 3 closed loop |
| ctrl_pdm | input | 1 | 0 pulse width, 1 pulse density |
| ctrl_ovf_cut | input | 1 | 1 lets an overflow open the drive switches |
| fixed_level | input | MW | Drive level for start and stop |
| demand | input | DW | Signed closed-loop demand, two's complement |
| drv_fwd | output | 1 | Forward drive line |
| drv_rev | output | 1 | Reverse drive line |
| sw_a_close | output | 1 | First drive switch, 1 closes it |
| sw_b_close | output | 1 | Second drive switch, 1 closes it |
| irq_ovf | output | 1 | Level overflow interrupt |

## Verification
The overflow interrupt and the switch cut-off can act in the same cycle. The bench provokes this by stepping the closed-loop demand past full scale with the cut-off bit set. At the next sample it expects the interrupt high and both switches open together. It then pulls the demand back into range and expects the interrupt to fall and the switches to close, again in a single cycle. The same step with the cut-off bit clear confirms that the interrupt rises while the switches stay closed.

// File: rtl/motor_drive_mod.sv
module motor_drive_mod #(
  parameter int DW = 12,
  parameter int MW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ctrl_mode,
  input  logic                 ctrl_pdm,
  input  logic                 ctrl_ovf_cut,
  input  logic [MW-1:0]        fixed_level,
  input  logic signed [DW-1:0] demand,
  output logic                 drv_fwd,
  output logic                 drv_rev,
  output logic                 sw_a_close,
  output logic                 sw_b_close,
  output logic                 irq_ovf
);
  localparam logic [1:0] M_OFF   = 2'd0;
  localparam logic [1:0] M_START = 2'd1;
  localparam logic [1:0] M_STOP  = 2'd2;
  localparam logic [1:0] M_LOOP  = 2'd3;
  localparam int FULL = (1 << MW) - 1;

  logic [DW-1:0] dem_u, dem_abs;
  logic          loop_ovf, rev_sel, drive_on, pwm_bit, mod_bit;
  logic [MW-1:0] loop_mag, mag, cnt, acc;
  logic [MW:0]   acc_sum;

  assign dem_u    = demand;
  assign dem_abs  = dem_u[DW-1] ? (~dem_u + 1'b1) : dem_u;
  assign loop_ovf = (ctrl_mode == M_LOOP) && (dem_abs > DW'(FULL));
  assign loop_mag = loop_ovf ? MW'(FULL) : dem_abs[MW-1:0];
  assign drive_on = (ctrl_mode != M_OFF);
  assign rev_sel  = (ctrl_mode == M_STOP) || ((ctrl_mode == M_LOOP) && dem_u[DW-1]);

  always_comb begin
    case (ctrl_mode)
      M_START, M_STOP: mag = fixed_level;
      M_LOOP:          mag = loop_mag;
      default:         mag = '0;
    endcase
  end

  assign acc_sum = {1'b0, acc} + {1'b0, mag};
  assign pwm_bit = (cnt < mag);
  assign mod_bit = ctrl_pdm ? acc_sum[MW] : pwm_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      acc        <= '0;
      drv_fwd    <= 1'b0;
      drv_rev    <= 1'b0;
      sw_a_close <= 1'b0;
      sw_b_close <= 1'b0;
      irq_ovf    <= 1'b0;
    end else begin
      cnt        <= cnt + 1'b1;
      acc        <= acc_sum[MW-1:0];
      drv_fwd    <= drive_on && !rev_sel && mod_bit;
      drv_rev    <= drive_on && rev_sel && mod_bit;
      sw_a_close <= drive_on && !(ctrl_ovf_cut && loop_ovf);
      sw_b_close <= drive_on && !(ctrl_ovf_cut && loop_ovf);
      irq_ovf    <= loop_ovf;
    end
  end

  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_mode) == M_OFF) |-> !(drv_fwd || drv_rev || sw_a_close || sw_b_close || irq_ovf)); // R2
  AST_START_NO_REV: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_mode) == M_START) |-> !drv_rev); // R3
  AST_STOP_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_mode) == M_STOP) |-> !drv_fwd); // R4
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_fwd && drv_rev)); // R5
  AST_IRQ_ONLY_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> ($past(ctrl_mode) == M_LOOP)); // R8
  AST_CUT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && $past(ctrl_ovf_cut)) |-> !(sw_a_close || sw_b_close)); // R10
endmodule

// File: tb/test_motor_drive_mod.sv
module test_motor_drive_mod;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        ctrl_mode = 2'd3;
  logic              ctrl_pdm = 1'b0;
  logic              ctrl_ovf_cut = 1'b0;
  logic [7:0]        fixed_level = 8'd0;
  logic signed [11:0] demand = 12'sd0;
  logic drv_fwd, drv_rev, sw_a_close, sw_b_close, irq_ovf;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  motor_drive_mod #(.DW(12), .MW(8)) i_motor_drive_mod (
    .clk(clk), .rst_n(rst_n), .ctrl_mode(ctrl_mode), .ctrl_pdm(ctrl_pdm),
    .ctrl_ovf_cut(ctrl_ovf_cut), .fixed_level(fixed_level), .demand(demand),
    .drv_fwd(drv_fwd), .drv_rev(drv_rev), .sw_a_close(sw_a_close),
    .sw_b_close(sw_b_close), .irq_ovf(irq_ovf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] m, input logic pdm, input logic cut,
                       input logic [7:0] lvl, input int dem);
    @(negedge clk);
    ctrl_mode = m; ctrl_pdm = pdm; ctrl_ovf_cut = cut;
    fixed_level = lvl; demand = 12'(dem);
    repeat (3) @(negedge clk);
  endtask

  task automatic measure(output int nf, output int nr, output int ef, output int er);
    logic pf, pr;
    nf = 0; nr = 0; ef = 0; er = 0;
    pf = drv_fwd; pr = drv_rev;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      nf += int'(drv_fwd); nr += int'(drv_rev);
      if (drv_fwd && !pf) ef++;
      if (drv_rev && !pr) er++;
      pf = drv_fwd; pr = drv_rev;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk({drv_fwd, drv_rev, sw_a_close, sw_b_close, irq_ovf} == 5'b0, "R1 reset outputs",
        int'({drv_fwd, drv_rev, sw_a_close, sw_b_close, irq_ovf}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_shutdown;
    int nf, nr, ef, er;
    setup(2'd0, 1'b0, 1'b1, 8'd200, 1000);
    measure(nf, nr, ef, er);
    chk(nf + nr == 0, "R2 shutdown drive", nf + nr, 0);
    chk(!sw_a_close && !sw_b_close && !irq_ovf, "R2 shutdown switches/irq",
        int'({sw_a_close, sw_b_close, irq_ovf}), 0);
  endtask

  task automatic t_start_stop;
    int nf, nr, ef, er;
    setup(2'd1, 1'b0, 1'b1, 8'd77, -900);
    measure(nf, nr, ef, er);
    chk(nf == 77 && nr == 0, "R3 start forward count", nf * 1000 + nr, 77000);
    chk(!irq_ovf, "R3 start ignores demand", int'(irq_ovf), 0);
    chk(sw_a_close && sw_b_close, "R11 switches closed in start", int'({sw_a_close, sw_b_close}), 3);
    setup(2'd2, 1'b1, 1'b0, 8'd190, 50);
    measure(nf, nr, ef, er);
    chk(nr == 190 && nf == 0, "R4 stop reverse count", nr * 1000 + nf, 190000);
    chk(sw_a_close && sw_b_close, "R11 switches closed in stop", int'({sw_a_close, sw_b_close}), 3);
  endtask

  task automatic t_loop;
    int nf, nr, ef, er;
    setup(2'd3, 1'b0, 1'b0, 8'd0, 100);
    measure(nf, nr, ef, er);
    chk(nf == 100 && nr == 0, "R5 positive demand", nf * 1000 + nr, 100000);
    chk(ef == 1, "R6 PWM one run per period", ef, 1);
    setup(2'd3, 1'b0, 1'b0, 8'd0, -37);
    measure(nf, nr, ef, er);
    chk(nr == 37 && nf == 0, "R5 negative demand", nr * 1000 + nf, 37000);
    setup(2'd3, 1'b1, 1'b0, 8'd0, 128);
    measure(nf, nr, ef, er);
    chk(nf == 128 && ef == 128, "R7 PDM alternating", nf * 1000 + ef, 128128);
    setup(2'd3, 1'b1, 1'b0, 8'd0, -3);
    measure(nf, nr, ef, er);
    chk(nr == 3 && er == 3, "R7 PDM spread low level", nr * 1000 + er, 3003);
    chk(sw_a_close && sw_b_close, "R11 switches closed in loop", int'({sw_a_close, sw_b_close}), 3);
  endtask

  task automatic t_overflow;
    int nf, nr, ef, er;
    setup(2'd3, 1'b0, 1'b1, 8'd0, 255);
    chk(!irq_ovf && sw_a_close, "R8 full scale no overflow", int'({irq_ovf, sw_a_close}), 1);
    demand = 12'sd256;
    @(negedge clk);
    chk(irq_ovf, "R8 irq rises", int'(irq_ovf), 1);
    chk(!sw_a_close && !sw_b_close, "R10 cut in same cycle", int'({sw_a_close, sw_b_close}), 0);
    demand = -12'sd255;
    @(negedge clk);
    chk(!irq_ovf && sw_a_close && sw_b_close, "R10 reclose with irq fall",
        int'({irq_ovf, sw_a_close, sw_b_close}), 3);
    setup(2'd3, 1'b0, 1'b0, 8'd0, -2000);
    chk(irq_ovf && sw_a_close && sw_b_close, "R10 no cut when disabled",
        int'({irq_ovf, sw_a_close, sw_b_close}), 7);
    measure(nf, nr, ef, er);
    chk(nr == 255 && nf == 0, "R9 saturation", nr * 1000 + nf, 255000);
    setup(2'd3, 1'b1, 1'b1, 8'd0, 2047);
    measure(nf, nr, ef, er);
    chk(nf == 255 && !sw_a_close, "R9 saturation PDM with cut", nf * 10 + int'(sw_a_close), 2550);
    setup(2'd0, 1'b0, 1'b1, 8'd0, 2047);
    chk(!irq_ovf, "R8 no irq outside loop", int'(irq_ovf), 0);
  endtask

  initial begin
    t_reset();
    t_shutdown();
    t_start_stop();
    t_loop();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule